// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the entry step of exception and interrupt handling for a 32-bit RISC pipeline with branch delay slots. In the cycle a synchronous exception is raised, or a qualified interrupt is accepted, it does several things at the clock edge:

- It records the return address, corrected for a delay slot and for system calls.
- It records the faulting address for illegal instructions.
- It saves the incoming status word and produces the supervisor-mode status word.
- It forms the handler address and pulses a strobe that clears the load-link reservation.

Two interrupt sources are arbitrated against their enable bits in the status word: an external line and a tick timer. A synchronous exception request always beats them. An out-of-range exception number raises an error pulse and leaves all state alone. The pipeline samples the outputs one cycle after the request. `taken` marks the cycle in which `nextPc` is the handler address.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rstN` is low, every output register is zero.
- R2: An accepted entry pulses `taken` for exactly the cycle after the request, and `epcOut` becomes `curPc` when there is no delay slot and the code is not a system call.
- R3: When `dslotIn` is high on entry, `epcOut` is `curPc - 4`, status bit 13 (delay-slot exception) is set in `srOut` and `dslotClr` pulses. Without a delay slot, bit 13 is cleared and `dslotClr` stays low.
- R4: For the system-call code (12), 4 is added to `epcOut` after the delay-slot correction.
- R5: For the illegal-instruction code (7), `eearOut` takes `curPc`. Any other entry leaves `eearOut` unchanged.
- R6: On entry, `esrOut` takes `srIn` unmodified. `srOut` takes `srIn` with these changes: bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU enable) and 6 (instruction MMU enable) cleared, and bit 0 (supervisor) set.
- R7: On entry, `nextPc` is the code shifted left by 8. It is ORed with `vecBase` when `vecBaseEn` is high, and with 0xF0000000 when `srIn` bit 14 (high vectors) is set.
- R8: Every entry pulses `resvClr` in the same cycle as `taken`.
- R9: With no synchronous request, the tick interrupt (code 5) is taken when `tickIrq` and `srIn` bit 1 are both high. Otherwise the external interrupt (code 8) is taken when `extIrq` and `srIn` bit 2 are both high. Tick wins when both qualify.
- R10: A valid synchronous request in the same cycle as a qualified interrupt enters with the request's code.
- R11: A request whose code is 0 or at least 14 pulses `badCode`, does not pulse `taken`, and leaves every saved register and `nextPc` unchanged.
- R12: A cycle with no request and no qualified interrupt changes no saved register and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excReq | input | 1 | Synchronous exception request |
| excCode | input | 5 | Exception number of the request |
| curPc | input | 32 | PC of the faulting or interrupted instruction |
| dslotIn | input | 1 | Instruction sits in a branch delay slot |
| srIn | input | 32 | Current status word |
| vecBase | input | 32 | Vector base register |
| vecBaseEn | input | 1 | Configuration: apply vector base |
| extIrq | input | 1 | External interrupt request |
| tickIrq | input | 1 | Tick timer interrupt request |
| epcOut | output | 32 | Saved return PC |
| eearOut | output | 32 | Saved effective address |
| esrOut | output | 32 | Saved status word |
| srOut | output | 32 | Status word after entry |
| nextPc | output | 32 | Handler address |
| taken | output | 1 | One-cycle entry pulse |
| resvClr | output | 1 | One-cycle load-link reservation clear |
| dslotClr | output | 1 | One-cycle delay-slot flag clear |
| badCode | output | 1 | One-cycle invalid exception number flag |

## Verification
The entry path is tried with plain, delay-slot and system-call requests, alone and combined. This separates the two return-PC corrections and their order. Illegal-instruction entries are followed by other entries to show that the fault address is written only for that code. Vector tests switch the base and high-prefix options on separately and together. Interrupt patterns cover:

- each source with its enable off and on;
- both sources at once;
- a request colliding with interrupts;
- out-of-range codes at 0, 14 and 31, checked against the saved state.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 5;
  // status word bit positions
  localparam int SR_SM  = 0;
  localparam int SR_TEE = 1;
  localparam int SR_IEE = 2;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_DSX = 13;
  localparam int SR_EPH = 14;

  typedef struct packed {
    logic              take;
    logic              bad;
    logic              isSyscall;
    logic              isIllegal;
    logic [CODE_W-1:0] code;
  } entryStb_t;
endpackage

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
  import exc_entry_pkg::*;
#(
  parameter int EXC_NUM      = 14,
  parameter int CODE_SYSCALL = 12,
  parameter int CODE_ILLEGAL = 7,
  parameter int CODE_EXT     = 8,
  parameter int CODE_TICK    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [XLEN-1:0]   srIn,
  input  logic              extIrq,
  input  logic              tickIrq,
  output entryStb_t         stb
);
  localparam logic [CODE_W-1:0] TickCode = CODE_W'(CODE_TICK);
  localparam logic [CODE_W-1:0] ExtCode  = CODE_W'(CODE_EXT);
  localparam logic [CODE_W-1:0] SysCode  = CODE_W'(CODE_SYSCALL);
  localparam logic [CODE_W-1:0] IllCode  = CODE_W'(CODE_ILLEGAL);

  logic codeOk, tickHit, extHit;

  assign codeOk  = (excCode != '0) && (int'(excCode) < EXC_NUM);
  assign tickHit = tickIrq && srIn[SR_TEE];
  assign extHit  = extIrq && srIn[SR_IEE];

  always_comb begin
    stb = '0;
    if (excReq) begin
      stb.take = codeOk;
      stb.bad  = !codeOk;
      stb.code = excCode;
    end else if (tickHit) begin
      stb.take = 1'b1;
      stb.code = TickCode;
    end else if (extHit) begin
      stb.take = 1'b1;
      stb.code = ExtCode;
    end
    stb.isSyscall = stb.take && (stb.code == SysCode);
    stb.isIllegal = stb.take && (stb.code == IllCode);
  end

  // R9: a tick entry needs its line and its enable
  a_r9_tick_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (stb.take && !excReq && stb.code == TickCode) |-> (tickIrq && srIn[SR_TEE]));
  // R9: qualified tick beats external
  a_r9_tick_wins: assert property (@(posedge clk) disable iff (!rstN)
    (!excReq && tickIrq && srIn[SR_TEE]) |-> (stb.take && stb.code == TickCode));
  // R11: an error never coincides with an entry
  a_r11_bad_excl: assert property (@(posedge clk) disable iff (!rstN)
    stb.bad |-> (excReq && !stb.take));
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] HIGH_PREFIX = 32'hF000_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  entryStb_t       stb,
  input  logic [XLEN-1:0] curPc,
  input  logic            dslotIn,
  input  logic [XLEN-1:0] srIn,
  input  logic [XLEN-1:0] vecBase,
  input  logic            vecBaseEn,
  output logic [XLEN-1:0] epcOut,
  output logic [XLEN-1:0] eearOut,
  output logic [XLEN-1:0] esrOut,
  output logic [XLEN-1:0] srOut,
  output logic [XLEN-1:0] nextPc,
  output logic            taken,
  output logic            resvClr,
  output logic            dslotClr,
  output logic            badCode
);
  localparam int PadW = XLEN - CODE_W - 8;

  logic [XLEN-1:0] retPc, srNew, vecPc;

  always_comb begin
    retPc = curPc;
    if (dslotIn)       retPc = retPc - XLEN'(4);
    if (stb.isSyscall) retPc = retPc + XLEN'(4);

    srNew = srIn;
    srNew[SR_DME] = 1'b0;
    srNew[SR_IME] = 1'b0;
    srNew[SR_IEE] = 1'b0;
    srNew[SR_TEE] = 1'b0;
    srNew[SR_SM]  = 1'b1;
    srNew[SR_DSX] = dslotIn;

    vecPc = {{PadW{1'b0}}, stb.code, 8'h00};
    if (vecBaseEn)    vecPc = vecPc | vecBase;
    if (srIn[SR_EPH]) vecPc = vecPc | HIGH_PREFIX;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epcOut   <= '0;
      eearOut  <= '0;
      esrOut   <= '0;
      srOut    <= '0;
      nextPc   <= '0;
      taken    <= 1'b0;
      resvClr  <= 1'b0;
      dslotClr <= 1'b0;
      badCode  <= 1'b0;
    end else begin
      taken    <= stb.take;
      resvClr  <= stb.take;
      dslotClr <= stb.take && dslotIn;
      badCode  <= stb.bad;
      if (stb.take) begin
        epcOut <= retPc;
        esrOut <= srIn;
        srOut  <= srNew;
        nextPc <= vecPc;
        if (stb.isIllegal) eearOut <= curPc;
      end
    end
  end

  // R6: supervisor bit is set after every entry
  a_r6_sm_set: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> srOut[SR_SM]);
  // R6: saved status equals the word presented at entry
  a_r6_esr_copy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(taken) |-> esrOut == $past(srIn));
  // R3: delay-slot exception bit follows the delay-slot input
  a_r3_dsx_track: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> srOut[SR_DSX] == $past(dslotIn));
  // R8: reservation clear travels with entry
  a_r8_resv_pair: assert property (@(posedge clk) disable iff (!rstN)
    resvClr == taken);
  // R11: bad code leaves handler address alone
  a_r11_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (badCode && !$past(taken)) |-> $stable(nextPc));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int EXC_NUM      = 14,
  parameter int CODE_SYSCALL = 12,
  parameter int CODE_ILLEGAL = 7,
  parameter int CODE_EXT     = 8,
  parameter int CODE_TICK    = 5,
  parameter logic [31:0] HIGH_PREFIX = 32'hF000_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        excReq,
  input  logic [4:0]  excCode,
  input  logic [31:0] curPc,
  input  logic        dslotIn,
  input  logic [31:0] srIn,
  input  logic [31:0] vecBase,
  input  logic        vecBaseEn,
  input  logic        extIrq,
  input  logic        tickIrq,
  output logic [31:0] epcOut,
  output logic [31:0] eearOut,
  output logic [31:0] esrOut,
  output logic [31:0] srOut,
  output logic [31:0] nextPc,
  output logic        taken,
  output logic        resvClr,
  output logic        dslotClr,
  output logic        badCode
);
  entryStb_t stb;

  exc_entry_ctl #(
    .EXC_NUM(EXC_NUM), .CODE_SYSCALL(CODE_SYSCALL), .CODE_ILLEGAL(CODE_ILLEGAL),
    .CODE_EXT(CODE_EXT), .CODE_TICK(CODE_TICK)
  ) uCtl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode),
    .srIn(srIn), .extIrq(extIrq), .tickIrq(tickIrq), .stb(stb)
  );

  exc_entry_dp #(.HIGH_PREFIX(HIGH_PREFIX)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .curPc(curPc), .dslotIn(dslotIn),
    .srIn(srIn), .vecBase(vecBase), .vecBaseEn(vecBaseEn),
    .epcOut(epcOut), .eearOut(eearOut), .esrOut(esrOut), .srOut(srOut),
    .nextPc(nextPc), .taken(taken), .resvClr(resvClr), .dslotClr(dslotClr),
    .badCode(badCode)
  );
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic excReq = 0, dslotIn = 0, vecBaseEn = 0, extIrq = 0, tickIrq = 0;
  logic [4:0]  excCode = '0;
  logic [31:0] curPc = '0, srIn = '0, vecBase = '0;
  logic [31:0] epcOut, eearOut, esrOut, srOut, nextPc;
  logic taken, resvClr, dslotClr, badCode;

  always #4 clk = ~clk;

  exc_entry_ctrl dut (.*);

  typedef struct {
    string tag;
    logic [31:0] epc, eear, esr, sr, pc;
    logic tk, rc, dc, bd;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mEpc = 0, mEear = 0, mEsr = 0, mSr = 0, mPc = 0;

  task automatic chk(string tag, string name, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, name, act, exp);
    end
  endtask

  task automatic step(string tag, bit req, logic [4:0] code, logic [31:0] pc,
                      bit ds, logic [31:0] sr, logic [31:0] base, bit cfg,
                      bit ext, bit tick);
    exp_t e;
    bit take, bad;
    logic [4:0] sel;
    logic [31:0] s;
    @(negedge clk);
    excReq = req; excCode = code; curPc = pc; dslotIn = ds; srIn = sr;
    vecBase = base; vecBaseEn = cfg; extIrq = ext; tickIrq = tick;
    take = 0; bad = 0; sel = 0;
    if (req) begin
      if (code != 0 && code < 14) begin take = 1; sel = code; end
      else bad = 1;
    end else if (tick && sr[1]) begin take = 1; sel = 5; end
    else if (ext && sr[2]) begin take = 1; sel = 8; end
    if (take) begin
      mEpc = pc - (ds ? 32'd4 : 32'd0) + ((sel == 12) ? 32'd4 : 32'd0);
      if (sel == 7) mEear = pc;
      mEsr = sr;
      s = sr & ~32'h0000_0066;
      s[0] = 1'b1;
      s[13] = ds;
      mSr = s;
      mPc = {19'd0, sel, 8'd0} | (cfg ? base : 32'd0) | (sr[14] ? 32'hF000_0000 : 32'd0);
    end
    e.tag = tag; e.epc = mEpc; e.eear = mEear; e.esr = mEsr; e.sr = mSr; e.pc = mPc;
    e.tk = take; e.rc = take; e.dc = take && ds; e.bd = bad;
    q.push_back(e);
  endtask

  // monitor: compare outputs 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "epc", epcOut, e.epc);
      chk(e.tag, "eear", eearOut, e.eear);
      chk(e.tag, "esr", esrOut, e.esr);
      chk(e.tag, "sr", srOut, e.sr);
      chk(e.tag, "nextPc", nextPc, e.pc);
      chk(e.tag, "taken", 32'(taken), 32'(e.tk));
      chk(e.tag, "resvClr", 32'(resvClr), 32'(e.rc));
      chk(e.tag, "dslotClr", 32'(dslotClr), 32'(e.dc));
      chk(e.tag, "badCode", 32'(badCode), 32'(e.bd));
    end
  end

  task automatic idle(string tag);
    step(tag, 0, 0, 32'h0, 0, 32'h0, 32'h0, 0, 0, 0);
  endtask

  initial begin
    #10;
    // R1: reset state
    chk("R1", "epc", epcOut, 0);
    chk("R1", "sr", srOut, 0);
    chk("R1", "nextPc", nextPc, 0);
    chk("R1", "taken", 32'(taken), 0);
    chk("R1", "resvClr", 32'(resvClr), 0);
    @(negedge clk); rstN = 1'b1;
    // R2 R6 R7 R8: plain entry
    step("R2", 1, 5'd3, 32'h0000_1000, 0, 32'h0000_0066, 32'h0, 0, 0, 0);
    idle("R12");
    // R3: delay slot
    step("R3", 1, 5'd2, 32'h0000_2000, 1, 32'h0000_0004, 32'h0, 0, 0, 0);
    step("R3", 1, 5'd2, 32'h0000_2100, 0, 32'h0000_2000, 32'h0, 0, 0, 0);
    // R4: system call, with and without delay slot
    step("R4", 1, 5'd12, 32'h0000_3000, 0, 32'h0, 32'h0, 0, 0, 0);
    step("R4", 1, 5'd12, 32'h0000_3100, 1, 32'h0, 32'h0, 0, 0, 0);
    // R5: illegal loads eear; another code keeps it
    step("R5", 1, 5'd7, 32'h0000_4444, 0, 32'h0, 32'h0, 0, 0, 0);
    step("R5", 1, 5'd9, 32'h0000_5555, 0, 32'h0, 32'h0, 0, 0, 0);
    // R7: base, prefix, both
    step("R7", 1, 5'd6, 32'h10, 0, 32'h0, 32'h0001_0000, 1, 0, 0);
    step("R7", 1, 5'd6, 32'h20, 0, 32'h0000_4000, 32'h0001_0000, 0, 0, 0);
    step("R7", 1, 5'd13, 32'h30, 0, 32'h0000_4060, 32'h0002_0000, 1, 0, 0);
    // R11: invalid codes
    step("R11", 1, 5'd0, 32'h40, 1, 32'hFFFF_FFFF, 32'h0, 1, 0, 0);
    step("R11", 1, 5'd14, 32'h44, 0, 32'h0, 32'h0, 0, 0, 0);
    step("R11", 1, 5'd31, 32'h48, 0, 32'h0, 32'h0, 0, 1, 1);
    // R9: enables and priority
    step("R9", 0, 0, 32'h50, 0, 32'h0, 32'h0, 0, 1, 1);
    step("R9", 0, 0, 32'h54, 0, 32'h0000_0004, 32'h0, 0, 1, 0);
    step("R9", 0, 0, 32'h58, 1, 32'h0000_0006, 32'h0, 0, 1, 1);
    step("R9", 0, 0, 32'h5C, 0, 32'h0000_0004, 32'h0, 0, 1, 1);
    step("R9", 0, 0, 32'h60, 0, 32'h0000_0002, 32'h0, 0, 0, 1);
    // R10: request beats interrupts
    step("R10", 1, 5'd4, 32'h70, 0, 32'h0000_0006, 32'h0, 0, 1, 1);
    idle("R12");
    idle("R12");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule